// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial control slave that gives an external host read and write access to a small file of eight-bit configuration registers. The host selects the port by pulling the active-low select line low. It then clocks one instruction byte followed by one data byte. The block samples the serial clock, the select line and the incoming data line with the block clock, so the serial clock must run well below the block clock. Every register is presented in parallel on `regs_o` for the logic around the port.

Read data can leave on one of two pins, and bit 7 of register 0 picks which one. In four-wire mode, which is the default, the shared data line stays an input and read data appears on the dedicated output pin. In three-wire mode the shared data line turns around and carries the read data, and the dedicated output pin is released. The pads are outside the block, so each data output comes with its own output-enable. A hardware reset input restores every register. A self-clearing soft reset bit restores every register except register 0.

The controller has five states. In IDLE the select line is high. In INSTR the instruction byte is shifted in. In WDATA the write data is shifted in. In RDATA the read data is shifted out. In DONE the byte is complete and further clocks are ignored. The transitions are as follows. IDLE goes to INSTR when select is seen low. INSTR goes to WDATA or RDATA on the eighth instruction rising edge, according to the read/write bit. WDATA and RDATA go to DONE on the eighth data rising edge. Every state returns to IDLE as soon as select is seen high.

Top module: `spi_cfg_port`

## Requirements
- R1: An instruction is 8 bits sent MSB first. Bit 7 = 1 means read and 0 means write. Bits 4:0 give the register address, and bits 6:5 are ignored. One data byte, MSB first, follows the instruction.
- R2: Incoming bits are taken on rising edges of `sclk`. Read bits are launched on falling edges of `sclk`, so the first read bit is valid after the first falling edge that follows the eighth instruction rising edge. The data outputs change only after a detected falling edge.
- R3: With register 0 bit 7 = 0 (four-wire, the default), read data is driven on `sdo_o` and `sdo_oe` is 1 during the read data byte. `sdio_oe` stays 0.
- R4: With register 0 bit 7 = 1 (three-wire), read data is driven on `sdio_o` and `sdio_oe` is 1 during the read data byte. `sdo_oe` stays 0, which means high impedance.
- R5: Select going high at any point returns the port to IDLE and drops both output enables. An interrupted write changes no register, and the next transaction starts from its first instruction bit.
- R6: While `rst` is 1, every register is restored to its default: register 0 becomes 00h and register k (1..7) becomes 40h+k.
- R7: Writing a 1 to register 0 bit 5 restores registers 1..7 to their defaults one clock after the write. The other register-0 bits keep the written value, and bit 5 clears at that same clock, so it reads back as 0.
- R8: There are 32 addresses, and only 0..7 are implemented. Reads of addresses 8..31 return 00h. Writes to them change no register, including the register whose low address bits match.
- R9: Extra `sclk` pulses after the data byte, while select stays low, change no register and drive nothing.
- R10: A completed write appears on `regs_o` (register k in bits 8k+7:8k) within a few block clocks after the last rising edge.
- R11: `sdio_oe` and `sdo_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst | input | 1 | Hardware reset, active high, synchronous |
| csb | input | 1 | Port select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side (three-wire reads) |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo_o | output | 1 | Dedicated read-data output (four-wire reads) |
| sdo_oe | output | 1 | Output enable for the dedicated output |
| regs_o | output | 64 | All implemented registers, register k at bits 8k+7:8k |

## Verification
The hardest case to reach from the ports is a soft reset issued while the port is already in three-wire mode. Register 0 must keep its direction bit while every other register falls back to its default, and the following read must turn the shared line around. The stimulus first writes non-default values into other registers. It then switches to three-wire mode, writes register 0 with both the direction bit and the soft reset bit set, and reads back on the shared line. Cut-off transactions are driven by raising select in the middle of a write data byte. Trailing clocks are driven by pulsing `sclk` after a complete write.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int BYTE_W   = 8;
    localparam int DIR_BIT  = 7;
    localparam int SRST_BIT = 5;
    localparam int RW_BIT   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } port_state_e;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        logic [BYTE_W-1:0] v;
        v = (idx == 0) ? '0 : BYTE_W'(8'h40 + idx);
        return v;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= pin_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_port_fsm.sv
module spi_port_fsm
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_active,
    output logic              dout
);
    localparam int CNT_W = $clog2(BYTE_W);

    port_state_e state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] instr_q, data_q, rd_sh_q;
    logic [BYTE_W-1:0] instr_nx, data_nx;
    logic              last_bit;

    assign instr_nx = {instr_q[BYTE_W-2:0], din};
    assign data_nx  = {data_q[BYTE_W-2:0], din};
    assign last_bit = sclk_rise && (cnt_q == CNT_W'(BYTE_W-1));
    assign rd_addr  = instr_nx[ADDR_W-1:0];
    assign rd_active = (state_q == ST_RDATA);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_act) state_d = ST_INSTR;
            ST_INSTR: if (last_bit) state_d = instr_nx[RW_BIT] ? ST_RDATA : ST_WDATA;
            ST_WDATA: if (last_bit) state_d = ST_DONE;
            ST_RDATA: if (last_bit) state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
        if (!cs_act) state_d = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            instr_q <= '0;
            data_q  <= '0;
            rd_sh_q <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            dout    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!cs_act) begin
                cnt_q <= '0;
            end else if (sclk_rise && (state_q == ST_INSTR || state_q == ST_WDATA ||
                                       state_q == ST_RDATA)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            unique case (state_q)
                ST_INSTR: if (cs_act && sclk_rise) begin
                    instr_q <= instr_nx;
                    if (last_bit && instr_nx[RW_BIT]) rd_sh_q <= rd_data;
                end
                ST_WDATA: if (cs_act && sclk_rise) begin
                    data_q <= data_nx;
                    if (last_bit) begin
                        wr_en   <= 1'b1;
                        wr_addr <= instr_q[ADDR_W-1:0];
                        wr_data <= data_nx;
                    end
                end
                ST_RDATA: if (cs_act && sclk_fall) begin
                    dout    <= rd_sh_q[BYTE_W-1];
                    rd_sh_q <= {rd_sh_q[BYTE_W-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int IMPL_REGS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [IMPL_REGS*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] mem_q [IMPL_REGS];
    logic srst_req;

    assign srst_req = mem_q[0][SRST_BIT];

    generate
        for (genvar i = 0; i < IMPL_REGS; i++) begin : g_reg
            if (i == 0) begin : g_ctrl
                always_ff @(posedge clk) begin
                    if (rst) begin
                        mem_q[i] <= reg_default(i);
                    end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                        mem_q[i] <= wr_data;
                    end else if (srst_req) begin
                        mem_q[i][SRST_BIT] <= 1'b0;
                    end
                end
            end else begin : g_plain
                always_ff @(posedge clk) begin
                    if (rst || srst_req) begin
                        mem_q[i] <= reg_default(i);
                    end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                        mem_q[i] <= wr_data;
                    end
                end
            end
            assign regs_flat[i*BYTE_W +: BYTE_W] = mem_q[i];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < IMPL_REGS; k++) begin
            if (rd_addr == ADDR_W'(k)) rd_data = mem_q[k];
        end
    end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int NUM_ADDR    = 32,
    parameter int IMPL_REGS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        csb,
    input  logic                        sclk,
    input  logic                        sdio_i,
    output logic                        sdio_o,
    output logic                        sdio_oe,
    output logic                        sdo_o,
    output logic                        sdo_oe,
    output logic [IMPL_REGS*BYTE_W-1:0] regs_o
);
    localparam int ADDR_W = $clog2(NUM_ADDR);

    logic [2:0] pins_s;
    logic       csb_s, sclk_s, sdio_s, sclk_d;
    logic       cs_act, sclk_rise, sclk_fall;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic       wr_en, rd_active, dout, three_wire;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin_i({csb, sclk, sdio_i}),
        .pin_o(pins_s)
    );

    assign {csb_s, sclk_s, sdio_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    assign cs_act    = ~csb_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    spi_port_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .din      (sdio_s),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_active(rd_active),
        .dout     (dout)
    );

    spi_reg_file #(.ADDR_W(ADDR_W), .IMPL_REGS(IMPL_REGS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .regs_flat(regs_o)
    );

    assign three_wire = regs_o[DIR_BIT];
    assign sdio_o  = dout;
    assign sdo_o   = dout;
    assign sdio_oe = rd_active & three_wire;
    assign sdo_oe  = rd_active & ~three_wire;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
    import spi_cfg_pkg::*;
#(
    parameter int IMPL_REGS = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cs_act,
    input logic                        sclk_fall,
    input logic                        sdio_oe,
    input logic                        sdo_oe,
    input logic                        sdo_o,
    input logic [IMPL_REGS*BYTE_W-1:0] regs_o
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe)); // R11

    AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!sdio_oe && !sdo_oe)); // R5

    AST_THREE_WIRE_SDO_HIZ: assert property (@(posedge clk) disable iff (rst)
        regs_o[DIR_BIT] |-> !sdo_oe); // R4

    AST_FOUR_WIRE_SDIO_IN: assert property (@(posedge clk) disable iff (rst)
        !regs_o[DIR_BIT] |-> !sdio_oe); // R3

    AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$past(sclk_fall) && !$past(rst)) |-> $stable(sdo_o)); // R2

    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        regs_o[SRST_BIT] |=> !regs_o[SRST_BIT]); // R7

    always @(posedge clk) begin
        if (rst_seen) begin
            AST_HW_RESET_CTRL: assert (regs_o[BYTE_W-1:0] == '0); // R6
        end
    end
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.IMPL_REGS(IMPL_REGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .sclk_fall(sclk_fall),
    .sdio_oe  (sdio_oe),
    .sdo_oe   (sdo_oe),
    .sdo_o    (sdo_o),
    .regs_o   (regs_o)
);

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 8;
    localparam int NREG       = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csb = 1'b1;
    logic sclk = 1'b0;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [NREG*8-1:0] regs_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] v; string tag; } item_t;
    item_t exp_q[$];
    item_t act_q[$];
    logic [7:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cfg_port dut (
        .clk(clk), .rst(rst), .csb(csb), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .regs_o(regs_o)
    );

    function automatic logic [7:0] dflt(input int k);
        return (k == 0) ? 8'h00 : 8'(8'h40 + k);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int k = 0; k < NREG; k++) model[k] = dflt(k);
    endtask

    task automatic pulse_sclk(input logic bitv);
        sdio_i = bitv;
        wait_clks(HALF_CLKS);
        sclk = 1'b1;
        wait_clks(HALF_CLKS);
        sclk = 1'b0;
    endtask

    // Driver: one full transaction; for reads pushes expected and actual bytes.
    task automatic xfer(input logic [7:0] instr, input logic [7:0] wdata,
                        input int extra, input string tag);
        logic [7:0] got;
        bit rd, tw;
        logic [4:0] a;
        rd = instr[7];
        a  = instr[4:0];
        tw = model[0][7];
        got = '0;
        if (rd) exp_q.push_back('{(a < NREG) ? model[a] : 8'h00, tag});
        csb = 1'b0;
        wait_clks(HALF_CLKS);
        for (int b = 7; b >= 0; b--) pulse_sclk(instr[b]);
        for (int b = 7; b >= 0; b--) begin
            sdio_i = rd ? 1'b0 : wdata[b];
            wait_clks(HALF_CLKS);
            if (rd) begin
                got[b] = tw ? sdio_o : sdo_o;
                if (b == 7) begin
                    if (tw) check(sdio_oe && !sdo_oe, "R4 enables in three-wire read", {sdio_oe, sdo_oe}, 2'b10);
                    else    check(sdo_oe && !sdio_oe, "R3 enables in four-wire read", {sdio_oe, sdo_oe}, 2'b01);
                end
            end
            sclk = 1'b1;
            wait_clks(HALF_CLKS);
            sclk = 1'b0;
        end
        for (int e = 0; e < extra; e++) pulse_sclk(1'b1);
        wait_clks(HALF_CLKS);
        csb = 1'b1;
        wait_clks(2 * HALF_CLKS);
        if (rd) act_q.push_back('{got, tag});
        else if (a < NREG) begin
            model[a] = wdata;
            if (a == 0 && wdata[5]) begin
                for (int k = 1; k < NREG; k++) model[k] = dflt(k);
                model[0][5] = 1'b0;
            end
        end
    endtask

    // Monitor: compares produced read bytes against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(a.v == e.v, e.tag, a.v, e.v);
            end
        end
    end

    task automatic check_regs(input string tag);
        for (int k = 0; k < NREG; k++)
            check(regs_o[8*k +: 8] == model[k], tag, regs_o[8*k +: 8], model[k]);
    endtask

    initial begin
        model_reset();
        wait_clks(5);
        rst = 1'b0;
        wait_clks(4);
        check_regs("R6 reset defaults");
        check(!sdio_oe && !sdo_oe, "R11 idle enables", {sdio_oe, sdo_oe}, 2'b00);

        xfer(8'h83, 8'h00, 0, "R1 R3 read reg3 four-wire");
        xfer(8'h02, 8'hA5, 0, "R1 write reg2");
        check(regs_o[8*2 +: 8] == 8'hA5, "R10 parallel view of reg2", regs_o[8*2 +: 8], 8'hA5);
        xfer(8'h82, 8'h00, 0, "R2 read back reg2");
        xfer(8'h64, 8'h3C, 0, "R1 write with bits 6:5 set");
        xfer(8'hE4, 8'h00, 0, "R1 read with bits 6:5 set");

        xfer(8'h09, 8'hFF, 0, "R8 write unimplemented");
        xfer(8'h89, 8'h00, 0, "R8 read unimplemented");
        xfer(8'h81, 8'h00, 0, "R8 no alias into reg1");
        check_regs("R8 no register changed");

        // R5: select raised in the middle of a write data byte
        csb = 1'b0;
        wait_clks(HALF_CLKS);
        for (int b = 7; b >= 0; b--) pulse_sclk(b < 3);
        for (int b = 0; b < 5; b++) pulse_sclk(1'b1);
        wait_clks(HALF_CLKS);
        csb = 1'b1;
        wait_clks(4);
        check(!sdio_oe && !sdo_oe, "R5 enables after abort", {sdio_oe, sdo_oe}, 2'b00);
        wait_clks(2 * HALF_CLKS);
        check(regs_o[8*7 +: 8] == model[7], "R5 aborted write left reg7", regs_o[8*7 +: 8], model[7]);
        xfer(8'h87, 8'h00, 0, "R5 fresh read after abort");

        xfer(8'h06, 8'h5A, 3, "R9 write with trailing clocks");
        check_regs("R9 registers after trailing clocks");
        xfer(8'h86, 8'h00, 0, "R9 read reg6");

        xfer(8'h00, 8'h80, 0, "R4 enter three-wire");
        xfer(8'h83, 8'h00, 0, "R4 read reg3 three-wire");
        xfer(8'h00, 8'hA1, 0, "R7 soft reset");
        check_regs("R7 registers after soft reset");
        xfer(8'h80, 8'h00, 0, "R7 reg0 keeps other bits");
        xfer(8'h82, 8'h00, 0, "R7 reg2 restored");

        xfer(8'h01, 8'h99, 0, "R6 write reg1 before reset");
        wait_clks(1);
        rst = 1'b1;
        wait_clks(3);
        rst = 1'b0;
        model_reset();
        wait_clks(4);
        check_regs("R6 hardware reset restores all");
        xfer(8'h80, 8'h00, 0, "R6 R3 read reg0 four-wire");

        wait_clks(10);
        check(exp_q.size() == 0 && act_q.size() == 0, "scoreboard drained", act_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule